// File: doc/BRIEF.md
# Windowed Register File

This block is the integer register file of a load/store processor whose procedure calls move a window instead of copying arguments. Eight global registers are visible at all times. The rest of the storage is a ring of register sets, each holding eight incoming-argument registers and eight private scratch registers. An instruction addresses 32 architectural registers: the globals, the current set's sixteen registers, and eight outgoing-argument registers. The outgoing registers are physically the incoming registers of the neighbouring set.

A window pointer selects the current set. A save command moves the pointer one set down the ring, so the caller's outgoing registers become the callee's incoming registers. A restore command moves it back. No data is copied in either case. A one-hot reserve mask marks one window that must not be entered. A save or restore that would enter the marked window leaves the pointer where it is and raises a one-cycle overflow or underflow flag, so that trap logic outside the block can spill or fill that window.

There are two combinational read ports and one synchronous write port. All three ports use the 5-bit architectural register number.

Top module: `wrf_top`

## Requirements
- R1: After reset the window pointer is 0, both flags are low, and every register reads 0.
- R2: Register number 0 always reads 0 on both read ports, and a write to register number 0 has no effect.
- R3: Register numbers 1 to 7 address the global registers, which are shared: the same value is seen from every window.
- R4: Register numbers 16 to 23 (private) and 24 to 31 (incoming) address storage that belongs to the current window alone. A value written there in one window is not seen in another window.
- R5: Register numbers 8 to 15 (outgoing) in window w address the same storage as numbers 24 to 31 in window (w-1) mod N, where N is the window count.
- R6: A save sets the pointer to (pointer-1) mod N. A restore sets it to (pointer+1) mod N. Both wrap around the ring and take effect at the clock edge.
- R7: If bit k of the one-hot reserve mask is set and a save targets window k, the pointer does not change and the overflow output is high for exactly the following cycle.
- R8: If a restore (without a save) targets the window marked in the reserve mask, the pointer does not change and the underflow output is high for exactly the following cycle.
- R9: Reads are combinational. A read of the register being written in the same cycle returns the old value, and the new value appears after the clock edge.
- R10: When save and restore are both asserted in the same cycle, the save takes effect and the restore is ignored.
- R11: The two read ports select their registers independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rs1_idx | input | 5 | Register number for read port 1 |
| rs1_data | output | DW | Read port 1 data |
| rs2_idx | input | 5 | Register number for read port 2 |
| rs2_data | output | DW | Read port 2 data |
| we | input | 1 | Write enable |
| rd_idx | input | 5 | Register number for the write port |
| wd | input | DW | Write data |
| save | input | 1 | Move the window to the callee |
| restore | input | 1 | Move the window back to the caller |
| wim | input | NWIN | One-hot reserve mask; bit k marks window k |
| cwp | output | $clog2(NWIN) | Current window pointer |
| ovf | output | 1 | Blocked save, one-cycle pulse |
| unf | output | 1 | Blocked restore, one-cycle pulse |

## Verification
The register mapping is tested with a distinct value written through each of the four register classes in one window, then read back after moving the window both ways. This tells shared globals apart from private registers and from the overlapping in/out registers. Pointer movement is driven until it wraps in both directions against two different reserve masks, which separates correct modulo arithmetic from off-by-one blocking. A write and a read of the same register in one cycle, and a save and restore asserted together, pin down the ordering rules.

// File: rtl/wrf_pkg.sv
package wrf_pkg;

    localparam int GLOBALS  = 8;
    localparam int SET_REGS = 16;
    localparam int GROUP    = 8;

    typedef enum logic [1:0] {
        CLS_GLOBAL,
        CLS_OUT,
        CLS_LOCAL,
        CLS_IN
    } reg_class_e;

    // The two upper bits of the architectural number select the class.
    function automatic reg_class_e classify(input logic [4:0] num);
        case (num[4:3])
            2'd0:    return CLS_GLOBAL;
            2'd1:    return CLS_OUT;
            2'd2:    return CLS_LOCAL;
            default: return CLS_IN;
        endcase
    endfunction

endpackage

// File: rtl/wrf_map.sv
module wrf_map
    import wrf_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int CW   = $clog2(NWIN),
    parameter int PW   = $clog2(GLOBALS + NWIN * SET_REGS)
) (
    input  logic [4:0]    arch,
    input  logic [CW-1:0] cwp,
    output logic [PW-1:0] phys
);

    logic [CW-1:0] prev_win;
    logic [PW-1:0] cur_base;
    logic [PW-1:0] prev_base;
    logic [PW-1:0] slot;

    always_comb begin
        prev_win  = (cwp == '0) ? CW'(NWIN - 1) : cwp - 1'b1;
        cur_base  = PW'(GLOBALS) + PW'(cwp) * PW'(SET_REGS);
        prev_base = PW'(GLOBALS) + PW'(prev_win) * PW'(SET_REGS);
        slot      = PW'(arch[2:0]);
        case (classify(arch))
            CLS_GLOBAL: phys = slot;
            CLS_OUT:    phys = prev_base + slot;
            CLS_LOCAL:  phys = cur_base + PW'(GROUP) + slot;
            default:    phys = cur_base + slot;
        endcase
    end

endmodule

// File: rtl/wrf_ctrl.sv
module wrf_ctrl #(
    parameter int NWIN = 8,
    parameter int CW   = $clog2(NWIN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            save,
    input  logic            restore,
    input  logic [NWIN-1:0] wim,
    output logic [CW-1:0]   cwp,
    output logic            ovf,
    output logic            unf
);

    typedef struct packed {
        logic [CW-1:0] cwp;
        logic          ovf;
        logic          unf;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic [CW-1:0] dec_win;
    logic [CW-1:0] inc_win;

    always_comb begin
        dec_win = (st_q.cwp == '0) ? CW'(NWIN - 1) : st_q.cwp - 1'b1;
        inc_win = (st_q.cwp == CW'(NWIN - 1)) ? '0 : st_q.cwp + 1'b1;
        st_d     = st_q;
        st_d.ovf = 1'b0;
        st_d.unf = 1'b0;
        if (save) begin
            if (wim[dec_win]) st_d.ovf = 1'b1;
            else              st_d.cwp = dec_win;
        end else if (restore) begin
            if (wim[inc_win]) st_d.unf = 1'b1;
            else              st_d.cwp = inc_win;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cwp = st_q.cwp;
    assign ovf = st_q.ovf;
    assign unf = st_q.unf;

endmodule

// File: rtl/wrf_store.sv
module wrf_store #(
    parameter int DW    = 32,
    parameter int NPHYS = 136,
    parameter int PW    = $clog2(NPHYS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [PW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [PW-1:0] raddr_a,
    output logic [DW-1:0] rdata_a,
    input  logic [PW-1:0] raddr_b,
    output logic [DW-1:0] rdata_b
);

    logic [DW-1:0] mem_q [NPHYS];
    logic [DW-1:0] mem_d [NPHYS];

    always_comb begin
        for (int i = 0; i < NPHYS; i++) begin
            mem_d[i] = mem_q[i];
            if (we && waddr == PW'(i)) mem_d[i] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NPHYS; i++) begin
            if (!rst_n) mem_q[i] <= '0;
            else        mem_q[i] <= mem_d[i];
        end
    end

    assign rdata_a = mem_q[raddr_a];
    assign rdata_b = mem_q[raddr_b];

endmodule

// File: rtl/wrf_top.sv
module wrf_top
    import wrf_pkg::*;
#(
    parameter int DW   = 32,
    parameter int NWIN = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [4:0]              rs1_idx,
    output logic [DW-1:0]           rs1_data,
    input  logic [4:0]              rs2_idx,
    output logic [DW-1:0]           rs2_data,
    input  logic                    we,
    input  logic [4:0]              rd_idx,
    input  logic [DW-1:0]           wd,
    input  logic                    save,
    input  logic                    restore,
    input  logic [NWIN-1:0]         wim,
    output logic [$clog2(NWIN)-1:0] cwp,
    output logic                    ovf,
    output logic                    unf
);

    localparam int CW     = $clog2(NWIN);
    localparam int NPHYS  = GLOBALS + NWIN * SET_REGS;
    localparam int PW     = $clog2(NPHYS);
    localparam int NPORTS = 3;   // two read ports and one write port

    logic [4:0]    arch_idx [NPORTS];
    logic [PW-1:0] phys_idx [NPORTS];
    logic [DW-1:0] raw_a, raw_b;
    logic          wr_ok;

    assign arch_idx[0] = rs1_idx;
    assign arch_idx[1] = rs2_idx;
    assign arch_idx[2] = rd_idx;

    wrf_ctrl #(.NWIN(NWIN), .CW(CW)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .save    (save),
        .restore (restore),
        .wim     (wim),
        .cwp     (cwp),
        .ovf     (ovf),
        .unf     (unf)
    );

    for (genvar p = 0; p < NPORTS; p++) begin : g_map
        wrf_map #(.NWIN(NWIN), .CW(CW), .PW(PW)) u_map (
            .arch (arch_idx[p]),
            .cwp  (cwp),
            .phys (phys_idx[p])
        );
    end

    assign wr_ok = we && (rd_idx != 5'd0);

    wrf_store #(.DW(DW), .NPHYS(NPHYS), .PW(PW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (wr_ok),
        .waddr   (phys_idx[2]),
        .wdata   (wd),
        .raddr_a (phys_idx[0]),
        .rdata_a (raw_a),
        .raddr_b (phys_idx[1]),
        .rdata_b (raw_b)
    );

    assign rs1_data = (rs1_idx == 5'd0) ? '0 : raw_a;
    assign rs2_data = (rs2_idx == 5'd0) ? '0 : raw_b;

endmodule

// File: rtl/wrf_checker.sv
module wrf_checker #(
    parameter int DW   = 32,
    parameter int NWIN = 8,
    parameter int CW   = $clog2(NWIN)
) (
    input logic            clk,
    input logic            rst_n,
    input logic [4:0]      rs1_idx,
    input logic [DW-1:0]   rs1_data,
    input logic [4:0]      rs2_idx,
    input logic [DW-1:0]   rs2_data,
    input logic            save,
    input logic            restore,
    input logic [NWIN-1:0] wim,
    input logic [CW-1:0]   cwp,
    input logic            ovf,
    input logic            unf
);

    logic [CW-1:0] lower, upper;
    assign lower = (cwp == '0) ? CW'(NWIN - 1) : cwp - 1'b1;
    assign upper = (cwp == CW'(NWIN - 1)) ? '0 : cwp + 1'b1;

    p_zero_rd1_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rs1_idx == 5'd0 |-> rs1_data == '0);
    p_zero_rd2_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rs2_idx == 5'd0 |-> rs2_data == '0);
    p_save_moves_r6: assert property (@(posedge clk) disable iff (!rst_n)
        save && !wim[lower] |=> cwp == $past(lower) && !ovf);
    p_restore_moves_r6: assert property (@(posedge clk) disable iff (!rst_n)
        restore && !save && !wim[upper] |=> cwp == $past(upper) && !unf);
    p_idle_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !save && !restore |=> $stable(cwp) && !ovf && !unf);
    p_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        save && wim[lower] |=> ovf && $stable(cwp));
    p_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        restore && !save && wim[upper] |=> unf && $stable(cwp));
    p_save_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        save && restore |=> !unf);
    p_flags_apart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf && unf));

endmodule

bind wrf_top wrf_checker #(.DW(DW), .NWIN(NWIN)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rs1_idx  (rs1_idx),
    .rs1_data (rs1_data),
    .rs2_idx  (rs2_idx),
    .rs2_data (rs2_data),
    .save     (save),
    .restore  (restore),
    .wim      (wim),
    .cwp      (cwp),
    .ovf      (ovf),
    .unf      (unf)
);

// File: tb/tb_wrf_top.sv
module tb_wrf_top;

    localparam int DW   = 32;
    localparam int NWIN = 8;
    localparam int CW   = $clog2(NWIN);

    logic          clk = 1'b0;
    logic          rst_n;
    logic [4:0]    rs1_idx, rs2_idx, rd_idx;
    logic [DW-1:0] rs1_data, rs2_data, wd;
    logic          we, save, restore;
    logic [NWIN-1:0] wim;
    logic [CW-1:0] cwp;
    logic          ovf, unf;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;   // 125 MHz

    wrf_top #(.DW(DW), .NWIN(NWIN)) dut (
        .clk(clk), .rst_n(rst_n),
        .rs1_idx(rs1_idx), .rs1_data(rs1_data),
        .rs2_idx(rs2_idx), .rs2_data(rs2_data),
        .we(we), .rd_idx(rd_idx), .wd(wd),
        .save(save), .restore(restore), .wim(wim),
        .cwp(cwp), .ovf(ovf), .unf(unf)
    );

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [4:0] idx, input logic [DW-1:0] val);
        we = 1'b1; rd_idx = idx; wd = val;
        step();
        we = 1'b0;
    endtask

    task automatic rd1(input logic [4:0] idx, output logic [DW-1:0] val);
        rs1_idx = idx;
        #1;
        val = rs1_data;
    endtask

    task automatic do_save();
        save = 1'b1; step(); save = 1'b0;
    endtask

    task automatic do_restore();
        restore = 1'b1; step(); restore = 1'b0;
    endtask

    task automatic t_reset();
        logic [DW-1:0] v;
        chk("R1 cwp", DW'(cwp), 0);
        chk("R1 ovf", DW'(ovf), 0);
        chk("R1 unf", DW'(unf), 0);
        rd1(5, v);  chk("R1 global", v, 0);
        rd1(20, v); chk("R1 local", v, 0);
    endtask

    task automatic t_zero();
        logic [DW-1:0] v;
        wr(0, 32'hDEAD_BEEF);
        rd1(0, v); chk("R2 port1", v, 0);
        rs2_idx = 0; #1; chk("R2 port2", rs2_data, 0);
    endtask

    task automatic t_overlap();
        logic [DW-1:0] v;
        wr(1, 32'h11); wr(8, 32'hA0); wr(16, 32'hB0); wr(24, 32'hC0);
        do_save();      // target window 7 is reserved
        chk("R7 ovf", DW'(ovf), 1);
        chk("R7 cwp", DW'(cwp), 0);
        step();
        chk("R7 pulse", DW'(ovf), 0);
        do_restore();
        chk("R6 restore", DW'(cwp), 1);
        chk("R6 unf", DW'(unf), 0);
        rd1(8, v);  chk("R5 outs=caller ins", v, 32'hC0);
        rd1(1, v);  chk("R3 global shared", v, 32'h11);
        rd1(16, v); chk("R4 local private", v, 0);
        rd1(24, v); chk("R4 in private", v, 0);
        wr(16, 32'h55);
        do_save();
        chk("R6 save", DW'(cwp), 0);
        rd1(16, v); chk("R4 local kept", v, 32'hB0);
        rd1(24, v); chk("R4 in kept", v, 32'hC0);
        rd1(8, v);  chk("R5 outs=set7 ins", v, 32'hA0);
    endtask

    task automatic t_underflow();
        for (int i = 1; i <= 6; i++) begin
            do_restore();
            chk("R6 climb", DW'(cwp), DW'(i));
        end
        do_restore();   // target 7 reserved
        chk("R8 unf", DW'(unf), 1);
        chk("R8 cwp", DW'(cwp), 6);
        step();
        chk("R8 pulse", DW'(unf), 0);
    endtask

    task automatic t_wrap();
        logic [DW-1:0] v;
        wim = 8'h08;
        do_restore(); chk("R6 to 7", DW'(cwp), 7);
        do_restore(); chk("R6 wrap up", DW'(cwp), 0);
        do_save();    chk("R6 wrap down", DW'(cwp), 7);
        rd1(24, v);   chk("R5 set7 ins", v, 32'hA0);
        do_restore(); chk("R6 back", DW'(cwp), 0);
    endtask

    task automatic t_rdw();
        rs1_idx = 17;
        we = 1'b1; rd_idx = 17; wd = 32'h77;
        #1; chk("R9 old value", rs1_data, 0);
        step();
        we = 1'b0;
        #1; chk("R9 new value", rs1_data, 32'h77);
    endtask

    task automatic t_both();
        save = 1'b1; restore = 1'b1;
        step();
        save = 1'b0; restore = 1'b0;
        chk("R10 save wins", DW'(cwp), 7);
        chk("R10 no unf", DW'(unf), 0);
        do_restore();
        chk("R10 return", DW'(cwp), 0);
    endtask

    task automatic t_ports();
        rs1_idx = 1; rs2_idx = 24;
        #1;
        chk("R11 port1", rs1_data, 32'h11);
        chk("R11 port2", rs2_data, 32'hC0);
    endtask

    initial begin
        #200000;
        bad++; total++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; we = 0; save = 0; restore = 0;
        rs1_idx = 0; rs2_idx = 0; rd_idx = 0; wd = 0;
        wim = 8'h80;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_zero();
        t_overlap();
        t_underflow();
        t_wrap();
        t_rdw();
        t_both();
        t_ports();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule